// File: doc/BRIEF.md
# Receive FIFO Character Timeout Detector

This block sits beside a UART receive FIFO and decides when unread data has waited long enough to justify an interrupt. It watches the FIFO occupancy, a strobe for each character the receiver writes into the FIFO, and a strobe for each host read of the receive buffer. It counts 16x baud ticks while data sits unread. When the idle window passes, it raises a pending flag that the interrupt identification logic reports as a character timeout.

The idle window is a whole number of character times. One character time is the frame length in bits multiplied by the oversampling ratio. The frame length covers the start bit, the data bits, the optional parity bit and one or two stop bits, and it follows the programmed format. A received character restarts the window, and so does a host read. A host read also clears a flag that is already pending. With the receive interrupt enable clear, the FIFO still fills, but no flag is ever produced.

Top module: `rx_timeout_det`

## Requirements
- R1: `timeout_pend` can only be high while `fifo_count` is nonzero. When `fifo_count` becomes zero, the flag is low after the next clock, and the idle window restarts from zero.
- R2: The flag rises only after more than `IDLE_CHARS` character times of baud ticks with no restart, counting ticks as `IDLE_CHARS * TICKS_PER_BIT * frame_bits`. Exactly that many ticks leave it low. The next tick makes it high one clock after the edge that registers that tick. For a 12-bit frame at 300 baud this gives 768 ticks, about 160 ms.
- R3: `frame_bits` = 1 start + data bits + parity + stop bits. Data bits come from `word_len`: 0→5, 1→6, 2→7, 3→8. Parity adds 1 when `parity_en` = 1.
- R4: With `two_stop` = 1 the frame has two stop bits, and both count in each character time. With `two_stop` = 0 it has one.
- R5: A `host_rd_stb` pulse clears a pending flag on the next clock and restarts the idle window from zero.
- R6: A `rx_char_stb` pulse restarts the idle window. It does not clear a flag that is already pending.
- R7: The window advances only in cycles where `baud_tick` is high. Cycles without a tick leave it unchanged.
- R8: While `rx_int_en` = 0, the flag is low from the next clock and the window is held at zero. After the enable is set again, a full new window is needed.
- R9: After reset the flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | CNT_W | Receive FIFO occupancy |
| rx_char_stb | input | 1 | One-cycle pulse per character written into the FIFO |
| host_rd_stb | input | 1 | One-cycle pulse per host read of the receive buffer |
| baud_tick | input | 1 | 16x oversampling tick |
| word_len | input | 2 | Data length code (0..3 → 5..8 bits) |
| parity_en | input | 1 | Parity bit present in frame |
| two_stop | input | 1 | Two stop bits when set |
| rx_int_en | input | 1 | Receive interrupt enable |
| timeout_pend | output | 1 | Character timeout pending |

## Verification
The hardest situation to reach is the exact edge of the window. The bench has to land precisely on the last tick that must not fire and then on the one tick that must. It also has to do this after a restart partway through the count. The stimulus drives `baud_tick` for an exact number of edges from a known restart point, waits idle cycles, and then adds a single tick. It repeats this for several frame formats, after a mid-window read, after a mid-window character, and after re-enabling. This shows that every restart source really returns the count to zero.

// File: rtl/rxto_pkg.sv
package rxto_pkg;

    typedef enum logic [1:0] {
        WL_5 = 2'd0,
        WL_6 = 2'd1,
        WL_7 = 2'd2,
        WL_8 = 2'd3
    } word_len_e;

    localparam int unsigned MAX_FRAME_BITS = 12;

    // start + (5 + code) data + parity + one or two stop bits
    function automatic logic [3:0] frame_bits(word_len_e wl, logic par, logic two);
        return 4'd7 + {2'b00, wl} + {3'b000, par} + {3'b000, two};
    endfunction

endpackage

// File: rtl/rxto_char_len.sv
module rxto_char_len
    import rxto_pkg::*;
#(
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned IDLE_CHARS    = 4,
    parameter int unsigned LIM_W         = 10
) (
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             two_stop,
    output logic [LIM_W-1:0] limit
);

    localparam int unsigned TICKS_PER_CHAR_BIT = IDLE_CHARS * TICKS_PER_BIT;

    logic [3:0] bits_d;

    always_comb begin
        bits_d = frame_bits(word_len_e'(word_len), parity_en, two_stop);
        limit  = LIM_W'(TICKS_PER_CHAR_BIT) * LIM_W'(bits_d);
    end

endmodule

// File: rtl/rxto_idle_timer.sv
module rxto_idle_timer #(
    parameter int unsigned LIM_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             baud_tick,
    input  logic [LIM_W-1:0] limit,
    output logic [LIM_W-1:0] elapsed,
    output logic             expired
);

    typedef struct packed {
        logic [LIM_W-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt = '0;
        end else if (baud_tick && (tmr_q.cnt <= limit)) begin
            tmr_d.cnt = tmr_q.cnt + LIM_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign elapsed = tmr_q.cnt;
    assign expired = (tmr_q.cnt > limit);

    p_hold_no_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud_tick && !restart) |=> $stable(tmr_q.cnt));

    p_restart_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (tmr_q.cnt == '0));

endmodule

// File: rtl/rxto_flag.sv
module rxto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic nonempty,
    input  logic host_rd,
    input  logic rx_char,
    input  logic expired,
    output logic pend
);

    typedef struct packed {
        logic pend;
    } flag_s;

    flag_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!enable || !nonempty || host_rd) begin
            st_d.pend = 1'b0;
        end else if (expired && !rx_char) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;

    p_empty_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |=> !pend);

    p_read_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd |=> !pend);

    p_disabled_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !pend);

    p_char_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && rx_char && !host_rd && nonempty && enable) |=> pend);

endmodule

// File: rtl/rx_timeout_det.sv
module rx_timeout_det
    import rxto_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH    = 32,
    parameter int unsigned TICKS_PER_BIT = 16,
    parameter int unsigned IDLE_CHARS    = 4,
    parameter int unsigned CNT_W         = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             rx_char_stb,
    input  logic             host_rd_stb,
    input  logic             baud_tick,
    input  logic [1:0]       word_len,
    input  logic             parity_en,
    input  logic             two_stop,
    input  logic             rx_int_en,
    output logic             timeout_pend
);

    localparam int unsigned MAX_LIMIT = IDLE_CHARS * TICKS_PER_BIT * MAX_FRAME_BITS;
    localparam int unsigned LIM_W     = $clog2(MAX_LIMIT + 2);

    logic [LIM_W-1:0] limit;
    logic [LIM_W-1:0] elapsed;
    logic             expired;
    logic             nonempty;
    logic             restart;

    assign nonempty = (fifo_count != '0);
    assign restart  = rx_char_stb | host_rd_stb | !nonempty | !rx_int_en;

    rxto_char_len #(
        .TICKS_PER_BIT (TICKS_PER_BIT),
        .IDLE_CHARS    (IDLE_CHARS),
        .LIM_W         (LIM_W)
    ) u_len (
        .word_len  (word_len),
        .parity_en (parity_en),
        .two_stop  (two_stop),
        .limit     (limit)
    );

    rxto_idle_timer #(
        .LIM_W (LIM_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .baud_tick (baud_tick),
        .limit     (limit),
        .elapsed   (elapsed),
        .expired   (expired)
    );

    rxto_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (rx_int_en),
        .nonempty (nonempty),
        .host_rd  (host_rd_stb),
        .rx_char  (rx_char_stb),
        .expired  (expired),
        .pend     (timeout_pend)
    );

    p_rise_after_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_pend) |-> ($past(elapsed) > $past(limit)));

endmodule

// File: tb/rx_timeout_det_tb.sv
module rx_timeout_det_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] fifo_count = '0;
    logic       rx_char_stb = 1'b0;
    logic       host_rd_stb = 1'b0;
    logic       baud_tick = 1'b0;
    logic [1:0] word_len = 2'd3;
    logic       parity_en = 1'b1;
    logic       two_stop = 1'b1;
    logic       rx_int_en = 1'b1;
    logic       timeout_pend;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        string req;
        logic  exp;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    rx_timeout_det u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_count   (fifo_count),
        .rx_char_stb  (rx_char_stb),
        .host_rd_stb  (host_rd_stb),
        .baud_tick    (baud_tick),
        .word_len     (word_len),
        .parity_en    (parity_en),
        .two_stop     (two_stop),
        .rx_int_en    (rx_int_en),
        .timeout_pend (timeout_pend)
    );

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_cmp++;
            if (timeout_pend !== e.exp) begin
                n_bad++;
                $display("FAIL %s: timeout_pend=%b expected %b at %0t",
                         e.req, timeout_pend, e.exp, $time);
            end
        end
    end

    task automatic expect_pend(input string req, input logic v);
        exp_t e;
        e.req = req;
        e.exp = v;
        sb_q.push_back(e);
        @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        baud_tick = 1'b1;
        repeat (n) @(posedge clk);
        #1;
        baud_tick = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_char_stb = 1'b1;
        @(posedge clk);
        #1;
        rx_char_stb = 1'b0;
    endtask

    task automatic pulse_rd();
        host_rd_stb = 1'b1;
        @(posedge clk);
        #1;
        host_rd_stb = 1'b0;
    endtask

    // drive exactly lim ticks (no fire), then one more (fires after one clock)
    task automatic window_edge(input string req, input int lim);
        ticks(lim);
        cycles(1);
        expect_pend(req, 1'b0);
        ticks(1);
        cycles(1);
        expect_pend(req, 1'b1);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run hung, actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        expect_pend("R9 reset", 1'b0);

        // R1: empty FIFO never times out
        ticks(800);
        cycles(2);
        expect_pend("R1 empty", 1'b0);

        // R2: 12-bit frame -> 4*16*12 = 768 ticks
        fifo_count = 6'd3;
        pulse_rx();
        ticks(768);
        cycles(2);
        expect_pend("R2 at limit", 1'b0);
        ticks(1);
        expect_pend("R2 latency", 1'b0);
        expect_pend("R2 fired", 1'b1);

        // R6: new character does not clear a pending flag
        pulse_rx();
        expect_pend("R6 keep", 1'b1);
        cycles(3);
        expect_pend("R6 keep later", 1'b1);

        // R5: read clears and restarts
        pulse_rd();
        expect_pend("R5 clear", 1'b0);
        window_edge("R5 restart", 768);

        // R6: character mid-window restarts the count
        pulse_rd();
        ticks(500);
        pulse_rx();
        window_edge("R6 restart", 768);

        // R5: read mid-window restarts the count
        pulse_rd();
        ticks(500);
        pulse_rd();
        window_edge("R5 mid read", 768);

        // R7: cycles without ticks do not advance
        pulse_rd();
        ticks(760);
        cycles(3000);
        expect_pend("R7 idle", 1'b0);
        window_edge("R7 resume", 8);

        // R4: one stop bit -> 11 bits -> 704 ticks
        two_stop = 1'b0;
        pulse_rd();
        window_edge("R4 one stop", 704);

        // R3: 5 data, no parity, one stop -> 7 bits -> 448 ticks
        word_len = 2'd0;
        parity_en = 1'b0;
        pulse_rd();
        window_edge("R3 min frame", 448);

        // R3: 6 data, parity, one stop -> 9 bits -> 576 ticks
        word_len = 2'd1;
        parity_en = 1'b1;
        pulse_rd();
        window_edge("R3 9-bit frame", 576);

        // R1: draining the FIFO clears the flag and restarts
        fifo_count = 6'd0;
        cycles(1);
        expect_pend("R1 drain", 1'b0);
        fifo_count = 6'd1;
        window_edge("R1 refill", 576);

        // R8: enable clear drops flag and holds the window
        rx_int_en = 1'b0;
        cycles(1);
        expect_pend("R8 disable", 1'b0);
        ticks(1000);
        cycles(1);
        expect_pend("R8 polled", 1'b0);
        rx_int_en = 1'b1;
        window_edge("R8 reenable", 576);

        done = 1'b1;
        cycles(2);
        finish_run();
    end

endmodule